// File: doc/BRIEF.md
# Receive Sampling Delay Calibrator

This block chooses the sampling delay applied to serial input data. When started, it applies each of four delay codes in turn. Code 0 means no extra delay, and codes 1, 2 and 3 add 2, 4 and 6 ns. After applying a code it issues one read of a known test register through a simple request/response port. It then compares the 16-bit reply with a fixed expected pattern.

The verdicts form a 4-bit pass mask, where bit i belongs to code i. A fixed rule turns this mask into the final delay code, which is then driven on the delay output. The rule prefers codes at the edge of the window or in its middle. If the passing codes do not form one unbroken run, the block reports a fault instead of a delay. A read that gets no reply within a bounded number of cycles is treated as a failing code.

The serial transport sits outside the block. It consumes `dly_code`, serves `rd_req` and returns `rd_vld`/`rd_data`.

Top module: `rxdly_calib`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `rd_req` are 0 and `dly_code` is 0.
- R2: A `start` pulse while idle begins a calibration. `busy` is 1 from the next cycle until `done` asserts. A `start` while busy is ignored and launches no extra reads.
- R3: Codes are applied in ascending order 0, 1, 2, 3. Each code is followed by exactly one single-cycle `rd_req` with `rd_addr` equal to `TEST_ADDR`, and `dly_code` shows that code while `rd_req` is high.
- R4: Mask bit i is set only when the reply to read i has `rd_data` equal to `PATTERN` (default 16'h5AA5). A `rd_vld` with no read pending is ignored.
- R5: If no `rd_vld` arrives within `TMO_CYC` cycles of a request, that code fails and the sequence moves on.
- R6: When exactly one bit of the mask is set, that code is chosen.
- R7: Two adjacent passes choose as follows: mask 4'b0011 gives 0, 4'b0110 gives 1, and 4'b1100 gives 3.
- R8: Three or four passes choose as follows: mask 4'b0111 gives 1, 4'b1110 gives 2, and 4'b1111 gives 1.
- R9: Any other mask, meaning zero or a set of passes with a gap, gives `fault` = 1 at `done`, with `dly_code` = 0.
- R10: `done` is a one-cycle pulse, and the chosen code is already on `dly_code` in that cycle. `dly_code` and `fault` then hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin calibration (ignored while busy) |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Pass window empty or broken |
| dly_code | output | 2 | Delay code applied to the sampler |
| rd_req | output | 1 | One-cycle test read request |
| rd_addr | output | ADDR_W | Address of the test register |
| rd_vld | input | 1 | Read reply valid |
| rd_data | input | DATA_W | Read reply data |

## Verification
All sixteen pass masks are driven directly. This separates each selection rule (R6–R8) from every fault mask, including the empty mask and masks with a gap. Random runs then vary the reply latency for each code and the way each code fails: either wrong data or no reply at all. This shows that a timeout and a data mismatch give the same verdict. Two directed cases check the ignore rules: a stray good reply while idle must not set a mask bit, and a second start during a run must launch no extra reads.

// File: rtl/rxdly_pkg.sv
package rxdly_pkg;
  localparam int NCODE  = 4;
  localparam int CODE_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET,
    ST_ISSUE,
    ST_WAIT,
    ST_DECIDE
  } cal_st_t;
endpackage

// File: rtl/rxdly_probe.sv
module rxdly_probe #(
  parameter int DATA_W           = 16,
  parameter logic [DATA_W-1:0] PATTERN = 16'h5AA5,
  parameter int TMO_CYC          = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  output logic              res_vld,
  output logic              res_pass
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);

  logic             pending;
  logic [CNT_W-1:0] cnt;
  logic             expired;

  assign expired  = (cnt == CNT_W'(TMO_CYC - 1));
  assign res_vld  = pending && (rd_vld || expired);
  assign res_pass = pending && rd_vld && (rd_data == PATTERN);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (arm) begin
      pending <= 1'b1;
      cnt     <= '0;
    end else if (pending) begin
      if (res_vld) pending <= 1'b0;
      else         cnt     <= cnt + 1'b1;
    end
  end

  // R5
  tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pending |-> (cnt < CNT_W'(TMO_CYC)));
endmodule

// File: rtl/rxdly_pick.sv
module rxdly_pick
  import rxdly_pkg::*;
(
  input  logic [NCODE-1:0]  mask,
  output logic [CODE_W-1:0] code,
  output logic              bad
);
  always_comb begin
    bad  = 1'b0;
    code = '0;
    case (mask)
      4'b0001: code = 2'd0;
      4'b0010: code = 2'd1;
      4'b0100: code = 2'd2;
      4'b1000: code = 2'd3;
      4'b0011: code = 2'd0;
      4'b0110: code = 2'd1;
      4'b1100: code = 2'd3;
      4'b0111: code = 2'd1;
      4'b1110: code = 2'd2;
      4'b1111: code = 2'd1;
      default: bad  = 1'b1;
    endcase
  end
endmodule

// File: rtl/rxdly_calib.sv
module rxdly_calib
  import rxdly_pkg::*;
#(
  parameter int ADDR_W                 = 16,
  parameter int DATA_W                 = 16,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 16'h0F40,
  parameter logic [DATA_W-1:0] PATTERN   = 16'h5AA5,
  parameter int TMO_CYC                = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [CODE_W-1:0] dly_code,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data
);
  cal_st_t           state;
  logic [CODE_W-1:0] idx;
  logic [NCODE-1:0]  mask;
  logic              res_vld, res_pass;
  logic [CODE_W-1:0] pick_code;
  logic              pick_bad;

  assign rd_addr = TEST_ADDR;

  rxdly_probe #(.DATA_W(DATA_W), .PATTERN(PATTERN), .TMO_CYC(TMO_CYC)) u_probe (
    .clk(clk), .rst(rst), .arm(state == ST_ISSUE),
    .rd_vld(rd_vld), .rd_data(rd_data),
    .res_vld(res_vld), .res_pass(res_pass)
  );

  rxdly_pick u_pick (.mask(mask), .code(pick_code), .bad(pick_bad));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      mask     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      fault    <= 1'b0;
      dly_code <= '0;
      rd_req   <= 1'b0;
    end else begin
      done   <= 1'b0;
      rd_req <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          idx      <= '0;
          mask     <= '0;
          busy     <= 1'b1;
          fault    <= 1'b0;
          dly_code <= '0;
          state    <= ST_SET;
        end
        ST_SET: begin
          dly_code <= idx;
          state    <= ST_ISSUE;
        end
        ST_ISSUE: begin
          rd_req <= 1'b1;
          state  <= ST_WAIT;
        end
        ST_WAIT: if (res_vld) begin
          mask[idx] <= res_pass;
          if (idx == CODE_W'(NCODE - 1)) begin
            state <= ST_DECIDE;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_SET;
          end
        end
        ST_DECIDE: begin
          dly_code <= pick_bad ? '0 : pick_code;
          fault    <= pick_bad;
          done     <= 1'b1;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  // R3
  req_code_stable_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (busy && dly_code == $past(dly_code)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> (dly_code == '0));
endmodule

// File: tb/rxdly_calib_test.sv
module rxdly_calib_test;
  localparam logic [15:0] PAT  = 16'h5AA5;
  localparam logic [15:0] TADR = 16'h0F40;
  localparam int          TMO  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done, fault;
  logic [1:0]  dly_code;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_vld = 1'b0;
  logic [15:0] rd_data = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  rxdly_calib #(.ADDR_W(16), .DATA_W(16), .TEST_ADDR(TADR), .PATTERN(PAT), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .fault(fault),
    .dly_code(dly_code), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic void exp_pick(input logic [3:0] m, output int c, output int f);
    int lo, hi, n;
    lo = -1; hi = -1; n = 0;
    for (int i = 0; i < 4; i++) if (m[i]) begin
      if (lo < 0) lo = i;
      hi = i;
      n++;
    end
    f = (n == 0 || (hi - lo + 1) != n) ? 1 : 0;
    c = 0;
    if (f == 0) begin
      if (n == 1)      c = lo;
      else if (n == 2) c = (lo == 0) ? 0 : ((hi == 3) ? 3 : lo);
      else if (n == 3) c = lo + 1;
      else             c = 1;
    end
  endfunction

  // mode: 0 random, 1 fail by bad data, 2 fail by timeout; restart: extra start mid-run
  task automatic run_cal(input logic [3:0] pm, input int mode, input bit restart);
    int ec, ef, g;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 busy after start", busy, 1);
    for (int i = 0; i < 4; i++) begin
      g = 0;
      while (!rd_req && g < 100) begin @(negedge clk); g++; end
      chk("R3 request issued", rd_req, 1);
      chk("R3 code order", dly_code, i);
      chk("R3 test address", rd_addr, TADR);
      if (restart && i == 1) start = 1'b1;
      if (pm[i]) begin
        repeat ($urandom % 7) @(negedge clk);
        start = 1'b0;
        rd_vld = 1'b1; rd_data = PAT;
        @(negedge clk) rd_vld = 1'b0;
      end else if (mode == 2 || (mode == 0 && $urandom % 2 == 0)) begin
        // R5: no reply, timeout
        @(negedge clk) start = 1'b0;
      end else begin
        repeat ($urandom % 7) @(negedge clk);
        start = 1'b0;
        rd_vld = 1'b1; rd_data = PAT ^ 16'(1 + $urandom % 16'hFFFF);
        @(negedge clk) rd_vld = 1'b0;
      end
    end
    g = 0;
    while (!done && g < TMO + 20) begin @(negedge clk); g++; end
    exp_pick(pm, ec, ef);
    chk("R10 done pulse", done, 1);
    chk("R2 busy low at done", busy, 0);
    chk("R6 R7 R8 R9 fault", fault, ef);
    chk("R6 R7 R8 R9 chosen code", dly_code, ec);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
    g = 0;
    for (int k = 0; k < 6; k++) begin
      if (rd_req) g++;
      @(negedge clk);
    end
    chk("R2 no extra reads", g, 0);
    chk("R10 code held", dly_code, ec);
    chk("R10 fault held", fault, ef);
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fault", fault, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 dly_code", dly_code, 0);

    // R6 R7 R8 R9: every mask, both failure styles
    for (int m = 0; m < 16; m++) run_cal(4'(m), 1, 1'b0);
    for (int m = 0; m < 16; m++) run_cal(4'(m), 2, 1'b0);

    // R4: stray good reply while idle must not count
    @(negedge clk) begin rd_vld = 1'b1; rd_data = PAT; end
    @(negedge clk) rd_vld = 1'b0;
    chk("R4 stray reply ignored", busy, 0);
    run_cal(4'b0000, 2, 1'b0);

    // R2: start while busy ignored
    run_cal(4'b0110, 1, 1'b1);

    // random mix
    for (int n = 0; n < 40; n++) run_cal(4'($urandom % 16), 0, ($urandom % 4) == 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule